// File: doc/BRIEF.md
# Dual-Modulus Alternating Clock Divider

This block derives a slow clock from a faster reference clock when the wanted frequency is not an integer fraction of the reference. It holds two integer divide ratios and alternates between them. The first ratio is used for a programmable number of output periods, then the second ratio for its own programmable number of periods, and the pattern repeats. Over one full pattern the mean output frequency is Fref × (M1 + M2) / (N1·M1 + N2·M2). A typical use is a 32.768 kHz timekeeping clock for an always-on low-power domain, built from a reference that is not a power-of-two multiple of it.

A mode input selects plain single-ratio division, in which only the first divide value matters. Every programmable count is given as the wanted value minus one. New settings are captured only at a sequence boundary, so a running pattern is never cut short. A one-cycle strobe marks the first reference cycle of every output period. The strobe can be removed with a parameter.

Top module: `dual_mod_clk_div`

## Requirements
- R1: While `rst` is high, `div_clk_o` and `period_stb_o` are low. In the first cycle after `rst` falls a new period starts on divider A, using the configuration present during the last reset cycle.
- R2: Each divide field and each repeat field encodes its value minus one. A field value f means f+1 reference cycles (divide) or f+1 periods (repeat), so 0 means 1 and 255 in `div_a` means 256.
- R3: With `dual_mode` = 0, every output period lasts `div_a`+1 reference cycles, whatever `div_b`, `rep_a` and `rep_b` hold.
- R4: With `dual_mode` = 1, the output gives `rep_a`+1 periods of `div_a`+1 cycles, then `rep_b`+1 periods of `div_b`+1 cycles, and repeats. One sequence therefore spans N1·M1 + N2·M2 reference cycles.
- R5: Each output period is low for its first ceil(N/2) reference cycles and high for the remaining floor(N/2). With N = 1 the output stays low.
- R6: `period_stb_o` is high for exactly one reference cycle, the first cycle of each output period, and at no other time.
- R7: A change of divide or repeat fields takes effect at the first sequence boundary after the change. In dual mode that boundary is the end of the last divider-B period. In single mode it is the end of the current period.
- R8: A change of `dual_mode` also waits for the next sequence boundary, so a dual sequence in progress completes before single operation begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1 = alternate two ratios, 0 = divider A only |
| div_a | input | DIV_W | Divider A length minus one |
| rep_a | input | REP_W | Periods on divider A minus one |
| div_b | input | DIV_W | Divider B length minus one |
| rep_b | input | REP_W | Periods on divider B minus one |
| div_clk_o | output | 1 | Divided clock |
| period_stb_o | output | 1 | One-cycle pulse at each period start |

## Verification
The hardest situation to reach is a configuration write that arrives in the middle of a dual sequence. Seen from the ports, the write must appear to do nothing for several periods and then take hold at exactly one boundary. The bench changes the inputs at a chosen period index, which it finds by counting strobes. It then compares every later period length against a model that tracks the position in the sequence and the point where the new settings become active. The same method covers the case where a mode change from dual to single must wait for the current pattern to complete.

// File: rtl/dmd_pkg.sv
`timescale 1ns/1ps
package dmd_pkg;
  // Which of the two ratios is currently driving the output.
  typedef enum logic {
    PH_A = 1'b0,
    PH_B = 1'b1
  } phase_e;
endpackage

// File: rtl/dmd_period_gen.sv
`timescale 1ns/1ps
// Counts reference cycles inside one output period and shapes the level.
module dmd_period_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] last_f,
  output logic             period_start,
  output logic             period_end,
  output logic             level
);
  localparam int LW = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q;

  // Cycle index at which the output goes high: ceil(len/2).
  function automatic logic [LW-1:0] rise_at(input logic [DIV_W-1:0] f);
    logic [LW-1:0] len;
    len = {1'b0, f} + 1'b1;
    return len - (len >> 1);
  endfunction

  assign period_end   = (cnt_q == last_f);
  assign period_start = !rst && (cnt_q == '0);
  assign level        = !rst && ({1'b0, cnt_q} >= rise_at(last_f));

  always_ff @(posedge clk) begin
    if (rst || period_end) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dmd_rep_ctr.sv
`timescale 1ns/1ps
// Counts output periods spent on the active ratio.
module dmd_rep_ctr #(
  parameter int REP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [REP_W-1:0] last_f,
  output logic             rep_last
);
  logic [REP_W-1:0] rep_q;

  assign rep_last = (rep_q == last_f);

  always_ff @(posedge clk) begin
    if (rst)           rep_q <= '0;
    else if (step) begin
      if (rep_last)    rep_q <= '0;
      else             rep_q <= rep_q + 1'b1;
    end
  end
endmodule

// File: rtl/dmd_seq_ctrl.sv
`timescale 1ns/1ps
// Holds the shadow configuration and steers between the two ratios.
module dmd_seq_ctrl
  import dmd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int REP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dual_in,
  input  logic [DIV_W-1:0] div_a_in,
  input  logic [REP_W-1:0] rep_a_in,
  input  logic [DIV_W-1:0] div_b_in,
  input  logic [REP_W-1:0] rep_b_in,
  input  logic             period_end,
  input  logic             rep_last,
  output logic [DIV_W-1:0] cur_div_f,
  output logic [REP_W-1:0] cur_rep_f,
  output logic             dual_q,
  output logic             rep_step,
  output logic             seq_end,
  output phase_e           phase
);
  logic [DIV_W-1:0] div_a_q, div_b_q;
  logic [REP_W-1:0] rep_a_q, rep_b_q;
  logic             swap;

  assign swap      = period_end && dual_q && rep_last;
  assign seq_end   = period_end && (!dual_q || (phase == PH_B && rep_last));
  assign rep_step  = period_end && dual_q;
  assign cur_div_f = (phase == PH_B) ? div_b_q : div_a_q;
  assign cur_rep_f = (phase == PH_B) ? rep_b_q : rep_a_q;

  always_ff @(posedge clk) begin
    if (rst || seq_end) begin
      dual_q  <= dual_in;
      div_a_q <= div_a_in;
      rep_a_q <= rep_a_in;
      div_b_q <= div_b_in;
      rep_b_q <= rep_b_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       phase <= PH_A;
    else if (swap) phase <= (phase == PH_A) ? PH_B : PH_A;
  end
endmodule

// File: rtl/dual_mod_clk_div.sv
`timescale 1ns/1ps
module dual_mod_clk_div
  import dmd_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int REP_W   = 6,
  parameter bit HAS_STB = 1'b1
) (
  input  logic             ref_clk,
  input  logic             rst,
  input  logic             dual_mode,
  input  logic [DIV_W-1:0] div_a,
  input  logic [REP_W-1:0] rep_a,
  input  logic [DIV_W-1:0] div_b,
  input  logic [REP_W-1:0] rep_b,
  output logic             div_clk_o,
  output logic             period_stb_o
);
  // Named internal events, observed by the bound checker.
  logic             period_start;
  logic             period_end;
  logic             seq_end;
  logic             rep_last;
  logic             rep_step;
  logic             dual_q;
  logic             level;
  logic [DIV_W-1:0] cur_div_f;
  logic [REP_W-1:0] cur_rep_f;
  phase_e           phase;
  logic             phase_b;

  assign phase_b = (phase == PH_B);

  dmd_seq_ctrl #(.DIV_W(DIV_W), .REP_W(REP_W)) u_seq (
    .clk        (ref_clk),
    .rst        (rst),
    .dual_in    (dual_mode),
    .div_a_in   (div_a),
    .rep_a_in   (rep_a),
    .div_b_in   (div_b),
    .rep_b_in   (rep_b),
    .period_end (period_end),
    .rep_last   (rep_last),
    .cur_div_f  (cur_div_f),
    .cur_rep_f  (cur_rep_f),
    .dual_q     (dual_q),
    .rep_step   (rep_step),
    .seq_end    (seq_end),
    .phase      (phase)
  );

  dmd_rep_ctr #(.REP_W(REP_W)) u_rep (
    .clk      (ref_clk),
    .rst      (rst),
    .step     (rep_step),
    .last_f   (cur_rep_f),
    .rep_last (rep_last)
  );

  dmd_period_gen #(.DIV_W(DIV_W)) u_per (
    .clk          (ref_clk),
    .rst          (rst),
    .last_f       (cur_div_f),
    .period_start (period_start),
    .period_end   (period_end),
    .level        (level)
  );

  assign div_clk_o = level;

  generate
    if (HAS_STB) begin : g_stb
      assign period_stb_o = period_start;
    end else begin : g_no_stb
      assign period_stb_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dual_mod_clk_div_chk.sv
`timescale 1ns/1ps
module dual_mod_clk_div_chk (
  input logic clk,
  input logic rst,
  input logic div_clk_o,
  input logic period_start,
  input logic period_end,
  input logic seq_end,
  input logic phase_b,
  input logic dual_q
);
  assert_restart_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (period_start && !phase_b));

  assert_start_low_R5: assert property (@(posedge clk) disable iff (rst)
    period_start |-> !div_clk_o);

  assert_next_start_R6: assert property (@(posedge clk) disable iff (rst)
    period_end |=> period_start);

  assert_no_stray_start_R6: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> !period_start);

  assert_single_no_b_R3: assert property (@(posedge clk) disable iff (rst)
    !dual_q |-> !phase_b);

  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !period_end |=> $stable(phase_b));

  assert_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    seq_end |-> period_end);

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !seq_end |=> $stable(dual_q));
endmodule

bind dual_mod_clk_div dual_mod_clk_div_chk u_chk (
  .clk          (ref_clk),
  .rst          (rst),
  .div_clk_o    (div_clk_o),
  .period_start (period_start),
  .period_end   (period_end),
  .seq_end      (seq_end),
  .phase_b      (phase_b),
  .dual_q       (dual_q)
);

// File: tb/dual_mod_clk_div_bench.sv
`timescale 1ns/1ps
module dual_mod_clk_div_bench;
  localparam int DW = 8;
  localparam int RW = 6;

  typedef struct packed {
    logic        dm;
    logic [7:0]  na;
    logic [5:0]  ma;
    logic [7:0]  nb;
    logic [5:0]  mb;
    logic [15:0] sc;   // expected reference cycles in one sequence
  } cfg_t;

  localparam int NV = 7;
  localparam cfg_t VEC [NV] = '{
    '{1'b0, 8'd3,   6'd2, 8'd9, 6'd9, 16'd4},
    '{1'b1, 8'd4,   6'd1, 8'd5, 6'd2, 16'd28},
    '{1'b1, 8'd0,   6'd0, 8'd2, 6'd0, 16'd4},
    '{1'b1, 8'd6,   6'd3, 8'd7, 6'd0, 16'd36},
    '{1'b0, 8'd0,   6'd5, 8'd3, 6'd3, 16'd1},
    '{1'b1, 8'd2,   6'd2, 8'd2, 6'd1, 16'd15},
    '{1'b1, 8'd1,   6'd4, 8'd0, 6'd4, 16'd15}
  };

  logic          ref_clk = 1'b0;
  logic          rst = 1'b1;
  logic          dual_mode = 1'b0;
  logic [DW-1:0] div_a = '0, div_b = '0;
  logic [RW-1:0] rep_a = '0, rep_b = '0;
  wire           div_clk_o, period_stb_o;

  int n_cmp = 0;
  int n_bad = 0;
  int plen [64];
  int phi  [64];
  int start_high;

  always #2.5 ref_clk = ~ref_clk;

  dual_mod_clk_div #(.DIV_W(DW), .REP_W(RW)) u_dual_mod_clk_div (
    .ref_clk      (ref_clk),
    .rst          (rst),
    .dual_mode    (dual_mode),
    .div_a        (div_a),
    .rep_a        (rep_a),
    .div_b        (div_b),
    .rep_b        (rep_b),
    .div_clk_o    (div_clk_o),
    .period_stb_o (period_stb_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input cfg_t c);
    dual_mode = c.dm; div_a = c.na; rep_a = c.ma; div_b = c.nb; rep_b = c.mb;
  endtask

  // Reference model: length of period k when config a switches to b during period chg.
  function automatic int exp_len(input cfg_t a, input cfg_t b, input int chg, input int k);
    cfg_t act = a;
    int pos = 0;
    int len = 0;
    for (int j = 0; j <= k; j++) begin
      int sl;
      if (!act.dm || pos < int'(act.ma) + 1) len = int'(act.na) + 1;
      else                                   len = int'(act.nb) + 1;
      sl = act.dm ? int'(act.ma) + int'(act.mb) + 2 : 1;
      pos++;
      if (pos == sl) begin
        pos = 0;
        if (chg >= 0 && j >= chg) act = b;
      end
    end
    return len;
  endfunction

  // Hold reset with config c, check quiet outputs, release at a falling edge.
  task automatic restart(input cfg_t c);
    @(negedge ref_clk);
    rst = 1'b1;
    apply(c);
    repeat (3) @(negedge ref_clk);
    chk("R1 clk low in reset", int'(div_clk_o), 0);
    chk("R1 strobe low in reset", int'(period_stb_o), 0);
    rst = 1'b0;
    #1;
    chk("R1 strobe right after release", int'(period_stb_o), 1);
  endtask

  // Measure nper complete periods; drive nc when period chg_at begins.
  task automatic capture(input int nper, input int chg_at, input cfg_t nc);
    int idx = -1;
    int len = 0;
    int hi = 0;
    start_high = 0;
    while (idx < nper) begin
      if (period_stb_o) begin
        if (idx >= 0) begin plen[idx] = len; phi[idx] = hi; end
        idx++;
        len = 0; hi = 0;
        if (div_clk_o) start_high++;
        if (idx == chg_at) apply(nc);
      end
      len++;
      if (div_clk_o) hi++;
      @(negedge ref_clk);
    end
  endtask

  task automatic compare(input string req, input int nper, input cfg_t a, input cfg_t b, input int chg);
    for (int k = 0; k < nper; k++) begin
      int e;
      e = exp_len(a, b, chg, k);
      chk(req, plen[k], e);
      chk("R5 high cycles", phi[k], e / 2);
    end
    chk("R5 low at period start", start_high, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cfg_t c;
    // Table walk: R3 single, R4 dual, R2 encodings at 0.
    for (int v = 0; v < NV; v++) begin
      int sl, sum;
      restart(VEC[v]);
      capture(12, -1, VEC[v]);
      compare(VEC[v].dm ? "R4 dual period" : "R3 single period", 12, VEC[v], VEC[v], -1);
      sl = VEC[v].dm ? int'(VEC[v].ma) + int'(VEC[v].mb) + 2 : 1;
      sum = 0;
      for (int k = 0; k < sl; k++) sum += plen[k];
      chk("R4 cycles per sequence", sum, int'(VEC[v].sc));
    end

    // R7: dual fields rewritten mid-sequence.
    restart(VEC[1]);
    capture(16, 2, VEC[5]);
    compare("R7 dual deferred update", 16, VEC[1], VEC[5], 2);

    // R7: single mode, new divide applies after the current period.
    c = VEC[0]; c.na = 8'd5;
    restart(VEC[0]);
    capture(8, 3, c);
    compare("R7 single update", 8, VEC[0], c, 3);

    // R8: switch dual to single mid-sequence.
    restart(VEC[3]);
    capture(12, 1, VEC[4]);
    compare("R8 mode change at boundary", 12, VEC[3], VEC[4], 1);

    // R3: divider B and repeat fields ignored in single mode.
    c = VEC[0]; c.nb = 8'd0; c.mb = 6'd0; c.ma = 6'd0;
    restart(VEC[0]);
    capture(8, 2, c);
    for (int k = 0; k < 8; k++) chk("R3 B fields ignored", plen[k], 4);

    // R2: largest divide field means 256 cycles.
    c = VEC[0]; c.na = 8'd255;
    restart(c);
    capture(3, -1, c);
    for (int k = 0; k < 3; k++) begin
      chk("R2 max divide length", plen[k], 256);
      chk("R5 max divide high", phi[k], 128);
    end

    // R1: reset in mid-run restarts on divider A.
    restart(VEC[6]);
    repeat (7) @(negedge ref_clk);
    rst = 1'b1;
    #1;
    chk("R1 clk low on mid-run reset", int'(div_clk_o), 0);
    chk("R1 strobe low on mid-run reset", int'(period_stb_o), 0);
    restart(VEC[1]);
    capture(4, -1, VEC[1]);
    chk("R1 first period on divider A", plen[0], 5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule